// File: doc/BRIEF.md
# Atomic Double-Width Compare-and-Swap Unit

This execution unit carries out one atomic compare-and-swap of a double-width value against memory. The caller supplies a high/low register pair that holds the value it expects to find, and a second high/low pair that holds the replacement. It also gives an address, a width select, and a few control inputs that decide whether the operation may run. In narrow mode each register half is 32 bits and the memory operand is 64 bits. In wide mode each half is 64 bits and the operand is 128 bits.

The unit runs a locked read followed by a locked write on a simple request/acknowledge memory port. A locked read always has a matching locked write: on a mismatch the old memory word goes back unchanged. The unit reports four results: an equality flag, the updated expected pair, a fault code, and a single-cycle completion pulse.

Faults are decided from the request alone, before any bus traffic. A faulting request completes without touching memory and leaves the flag and the register pair as they were. A new request is taken only while the unit is idle.

Top module: `cas_unit`

## Requirements
- R1: The compare value is the expected high half placed above the expected low half, and the replacement value is built the same way from its own pair. When the memory word equals the compare value, the unit sets `eq_flag` to 1, writes the replacement to memory and returns the expected pair unchanged on `res_hi`/`res_lo`.
- R2: When the memory word differs, the unit clears `eq_flag` to 0 and writes the word it read back to memory unchanged. It returns that word split so that its upper half appears on `res_hi` and its lower half on `res_lo`. In narrow mode the upper 32 bits of each result half are zero.
- R3: Every operation that completes without a fault makes exactly one memory read and then exactly one memory write.
- R4: `mem_lock` rises with the read request and stays high without a gap until the write is acknowledged.
- R5: In wide mode, an address whose low four bits are not all zero raises general-protection fault code 2. This holds whatever the alignment-check enable and privilege level are.
- R6: In wide mode, when `wide_feat_en` is 0, the request raises fault code 2.
- R7: When `is_mem_opnd` is 0, the request raises undefined-opcode fault code 1. This fault takes priority over every other fault.
- R8: In narrow mode, an address whose low three bits are not all zero raises alignment fault code 3 only when `align_chk_en` is 1 and `cpl` equals 3. Otherwise the operation runs normally.
- R9: A faulting request makes no memory access. It leaves `eq_flag` at its previous value and returns the supplied expected pair on `res_hi`/`res_lo`. A request with no fault reports code 0.
- R10: A request is accepted only while `req_ready` is 1, and `req_ready` is 0 from acceptance until completion. `done` is high for exactly one cycle per operation, and the results are valid in that cycle.
- R11: In wide mode the full 128-bit word is compared, written and returned. The expected high register occupies bits 127:64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Unit idle, request can be accepted |
| req_wide | input | 1 | 1 = 128-bit operation, 0 = 64-bit |
| req_addr | input | ADDR_W | Byte address of the memory operand |
| exp_hi | input | HALF_W | Expected value, high half |
| exp_lo | input | HALF_W | Expected value, low half |
| new_hi | input | HALF_W | Replacement value, high half |
| new_lo | input | HALF_W | Replacement value, low half |
| align_chk_en | input | 1 | Alignment checking enabled |
| cpl | input | 2 | Current privilege level |
| is_mem_opnd | input | 1 | Destination is a memory operand |
| wide_feat_en | input | 1 | Wide operation permitted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Locked sequence in progress |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 2*HALF_W | Write data, narrow value in low 64 bits |
| mem_rdata | input | 2*HALF_W | Read data |
| mem_ack | input | 1 | Access completes this cycle |
| done | output | 1 | One-cycle completion pulse |
| eq_flag | output | 1 | Equality flag |
| res_hi | output | HALF_W | Updated expected value, high half |
| res_lo | output | HALF_W | Updated expected value, low half |
| fault | output | 2 | 0 none, 1 undefined opcode, 2 general protection, 3 alignment |

## Verification
The bench issues both a matching and a mismatching swap at each width. If a design skipped the write on a mismatch, the bench's write count would come up short. If it swapped the halves, the returned pair would not match. If it compared only 64 bits in wide mode, it would report a false match.

The misaligned cases target the per-width rules. A wide misaligned request with alignment checking off must still fault. A narrow misaligned request must fault only at privilege level 3 with checking on. A non-memory request that is also misaligned must report the undefined-opcode code.

After each fault the bench confirms that no read or write reached memory and that the flag kept its earlier value. Every cycle, a monitor also watches for any gap in the lock between the read and the write.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2,
    FLT_AC   = 2'd3
  } cas_fault_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ    = 3'd1,
    ST_COMPARE = 3'd2,
    ST_WRITE   = 3'd3,
    ST_DONE    = 3'd4
  } cas_state_e;

endpackage

// File: rtl/cas_fault_chk.sv
module cas_fault_chk
  import cas_pkg::*;
#(
  parameter int WIDE_ALIGN_BITS   = 4,
  parameter int NARROW_ALIGN_BITS = 3,
  parameter int USER_CPL          = 3
) (
  input  logic                       wide,
  input  logic [WIDE_ALIGN_BITS-1:0] addr_low,
  input  logic                       is_mem,
  input  logic                       wide_en,
  input  logic                       ac_en,
  input  logic [1:0]                 cpl,
  output cas_fault_e                 flt
);

  logic wide_mis;
  logic narrow_mis;

  always_comb begin
    wide_mis   = |addr_low;
    narrow_mis = |addr_low[NARROW_ALIGN_BITS-1:0];
    // undefined opcode first, then protection, then alignment
    if (!is_mem)
      flt = FLT_UD;
    else if (wide && (!wide_en || wide_mis))
      flt = FLT_GP;
    else if (!wide && narrow_mis && ac_en && (cpl == 2'(USER_CPL)))
      flt = FLT_AC;
    else
      flt = FLT_NONE;
  end

endmodule

// File: rtl/cas_datapath.sv
module cas_datapath #(
  parameter int HALF_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              wide_in,
  input  logic [HALF_W-1:0] exp_hi_in,
  input  logic [HALF_W-1:0] exp_lo_in,
  input  logic [HALF_W-1:0] new_hi_in,
  input  logic [HALF_W-1:0] new_lo_in,
  input  logic              rd_en,
  input  logic [2*HALF_W-1:0] rdata,
  input  logic              cmp_en,
  output logic [2*HALF_W-1:0] wdata,
  output logic              eq_flag,
  output logic [HALF_W-1:0] res_hi,
  output logic [HALF_W-1:0] res_lo
);

  localparam int DW = 2 * HALF_W;
  localparam int NW = HALF_W / 2;
  localparam int PAD = HALF_W - NW;

  logic          wide_q;
  logic [DW-1:0] exp_q, new_q, rd_q, wdata_q;
  logic          eq_q;
  logic [HALF_W-1:0] res_hi_q, res_lo_q;
  logic          match;

  function automatic logic [DW-1:0] pack_pair(input logic w,
                                              input logic [HALF_W-1:0] hi,
                                              input logic [HALF_W-1:0] lo);
    if (w) return {hi, lo};
    else   return {{HALF_W{1'b0}}, hi[NW-1:0], lo[NW-1:0]};
  endfunction

  assign match = (rd_q == exp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q   <= 1'b0;
      exp_q    <= '0;
      new_q    <= '0;
      rd_q     <= '0;
      wdata_q  <= '0;
      eq_q     <= 1'b0;
      res_hi_q <= '0;
      res_lo_q <= '0;
    end else begin
      if (load_en) begin
        wide_q   <= wide_in;
        exp_q    <= pack_pair(wide_in, exp_hi_in, exp_lo_in);
        new_q    <= pack_pair(wide_in, new_hi_in, new_lo_in);
        res_hi_q <= exp_hi_in;
        res_lo_q <= exp_lo_in;
      end
      if (rd_en)
        rd_q <= wide_q ? rdata : {{HALF_W{1'b0}}, rdata[HALF_W-1:0]};
      if (cmp_en) begin
        eq_q    <= match;
        wdata_q <= match ? new_q : rd_q;
        if (!match) begin
          if (wide_q) begin
            res_hi_q <= rd_q[DW-1:HALF_W];
            res_lo_q <= rd_q[HALF_W-1:0];
          end else begin
            res_hi_q <= {{PAD{1'b0}}, rd_q[HALF_W-1:NW]};
            res_lo_q <= {{PAD{1'b0}}, rd_q[NW-1:0]};
          end
        end
      end
    end
  end

  assign wdata   = wdata_q;
  assign eq_flag = eq_q;
  assign res_hi  = res_hi_q;
  assign res_lo  = res_lo_q;

  // R1
  cmp_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && (rd_q == exp_q)) |=> (eq_flag && wdata == $past(new_q)));

  // R2
  miss_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && (rd_q != exp_q)) |=> (!eq_flag && wdata == $past(rd_q)));

endmodule

// File: rtl/cas_seq.sv
module cas_seq
  import cas_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] addr_in,
  input  cas_fault_e        flt_in,
  input  logic              mem_ack,
  output logic              ready,
  output logic              load_en,
  output logic              rd_en,
  output logic              cmp_en,
  output logic              done,
  output logic [1:0]        fault_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr
);

  cas_state_e        st_q, st_d;
  cas_fault_e        flt_q;
  logic [ADDR_W-1:0] addr_q;

  assign ready   = (st_q == ST_IDLE);
  assign load_en = ready && req_valid;
  assign rd_en   = (st_q == ST_READ) && mem_ack;
  assign cmp_en  = (st_q == ST_COMPARE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (req_valid) st_d = (flt_in != FLT_NONE) ? ST_DONE : ST_READ;
      ST_READ:    if (mem_ack) st_d = ST_COMPARE;
      ST_COMPARE: st_d = ST_WRITE;
      ST_WRITE:   if (mem_ack) st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      flt_q  <= FLT_NONE;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (load_en) begin
        flt_q  <= flt_in;
        addr_q <= addr_in;
      end
    end
  end

  assign done     = (st_q == ST_DONE);
  assign fault_o  = flt_q;
  assign mem_req  = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign mem_we   = (st_q == ST_WRITE);
  assign mem_lock = (st_q == ST_READ) || (st_q == ST_COMPARE) || (st_q == ST_WRITE);
  assign mem_addr = addr_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_lock && !(mem_we && mem_ack)) |=> mem_lock);

  // R9
  fault_nobus_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && flt_q != FLT_NONE) |-> !mem_req);

endmodule

// File: rtl/cas_unit.sv
module cas_unit
  import cas_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_wide,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [HALF_W-1:0]   exp_hi,
  input  logic [HALF_W-1:0]   exp_lo,
  input  logic [HALF_W-1:0]   new_hi,
  input  logic [HALF_W-1:0]   new_lo,
  input  logic                align_chk_en,
  input  logic [1:0]          cpl,
  input  logic                is_mem_opnd,
  input  logic                wide_feat_en,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_lock,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*HALF_W-1:0] mem_wdata,
  input  logic [2*HALF_W-1:0] mem_rdata,
  input  logic                mem_ack,
  output logic                done,
  output logic                eq_flag,
  output logic [HALF_W-1:0]   res_hi,
  output logic [HALF_W-1:0]   res_lo,
  output logic [1:0]          fault
);

  localparam int WIDE_BYTES = (2 * HALF_W) / 8;
  localparam int ALIGN_BITS = $clog2(WIDE_BYTES);

  cas_fault_e flt;
  logic load_en, rd_en, cmp_en;

  cas_fault_chk #(
    .WIDE_ALIGN_BITS  (ALIGN_BITS),
    .NARROW_ALIGN_BITS(ALIGN_BITS - 1),
    .USER_CPL         (3)
  ) i_fault (
    .wide    (req_wide),
    .addr_low(req_addr[ALIGN_BITS-1:0]),
    .is_mem  (is_mem_opnd),
    .wide_en (wide_feat_en),
    .ac_en   (align_chk_en),
    .cpl     (cpl),
    .flt     (flt)
  );

  cas_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .addr_in  (req_addr),
    .flt_in   (flt),
    .mem_ack  (mem_ack),
    .ready    (req_ready),
    .load_en  (load_en),
    .rd_en    (rd_en),
    .cmp_en   (cmp_en),
    .done     (done),
    .fault_o  (fault),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_lock (mem_lock),
    .mem_addr (mem_addr)
  );

  cas_datapath #(.HALF_W(HALF_W)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .wide_in  (req_wide),
    .exp_hi_in(exp_hi),
    .exp_lo_in(exp_lo),
    .new_hi_in(new_hi),
    .new_lo_in(new_lo),
    .rd_en    (rd_en),
    .rdata    (mem_rdata),
    .cmp_en   (cmp_en),
    .wdata    (mem_wdata),
    .eq_flag  (eq_flag),
    .res_hi   (res_hi),
    .res_lo   (res_lo)
  );

  // R3
  write_before_done_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault == 2'd0) |-> $past(mem_req && mem_we && mem_ack));

  // R9
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault != 2'd0) |-> (eq_flag == $past(eq_flag)));

endmodule

// File: tb/test_cas_unit.sv
module test_cas_unit;

  localparam int HALF_W = 64;
  localparam int ADDR_W = 32;
  localparam int DW = 2 * HALF_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              req_valid = 0, req_wide = 0, align_chk_en = 0, is_mem_opnd = 1, wide_feat_en = 1;
  logic [1:0]        cpl = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [HALF_W-1:0] exp_hi = '0, exp_lo = '0, new_hi = '0, new_lo = '0;
  logic req_ready, mem_req, mem_we, mem_lock, done, eq_flag;
  logic [ADDR_W-1:0] mem_addr;
  logic [DW-1:0]     mem_wdata, mem_rdata;
  logic              mem_ack;
  logic [HALF_W-1:0] res_hi, res_lo;
  logic [1:0]        fault;

  cas_unit #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) i_cas_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_wide(req_wide), .req_addr(req_addr), .exp_hi(exp_hi), .exp_lo(exp_lo),
    .new_hi(new_hi), .new_lo(new_lo), .align_chk_en(align_chk_en), .cpl(cpl),
    .is_mem_opnd(is_mem_opnd), .wide_feat_en(wide_feat_en), .mem_req(mem_req),
    .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .done(done), .eq_flag(eq_flag),
    .res_hi(res_hi), .res_lo(res_lo), .fault(fault)
  );

  // behavioural memory: 32 doublewords, one-cycle acknowledge
  logic [63:0] bmem [32];
  logic        cur_wide = 0;
  int          n_rd = 0, n_wr = 0, lock_gaps = 0;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  bit          in_lock = 0;
  bit          model_eq = 0;
  logic [4:0]  ridx;

  assign ridx      = mem_addr[7:3];
  assign mem_rdata = {bmem[ridx + 5'd1], bmem[ridx]};

  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack && !mem_we) n_rd <= n_rd + 1;
      if (mem_req && mem_ack && mem_we) begin
        n_wr <= n_wr + 1;
        bmem[ridx] <= mem_wdata[63:0];
        if (cur_wide) bmem[ridx + 5'd1] <= mem_wdata[127:64];
      end
    end
  end

  // lock monitor, sampled away from the edge (R4)
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req && !mem_we && mem_ack) in_lock = 1;
      if (in_lock && !mem_lock) lock_gaps++;
      if (mem_req && mem_we && mem_ack) in_lock = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<50000", cyc);
        finish_run();
      end
    end
  end

  task automatic run_op(input string tag, input bit w, input logic [31:0] a,
                        input logic [63:0] ehi, input logic [63:0] elo,
                        input logic [63:0] nhi, input logic [63:0] nlo,
                        input bit ac, input logic [1:0] pl, input bit ism, input bit wen);
    logic [1:0]    xf;
    logic [127:0]  memv, cmpv, newv, after;
    logic [4:0]    ix;
    bit            xeq;
    logic [63:0]   xhi, xlo;
    int            rd0, wr0, guard;
    ix = a[7:3];
    if (!ism) xf = 2'd1;
    else if (w && (!wen || a[3:0] != 0)) xf = 2'd2;
    else if (!w && a[2:0] != 0 && ac && pl == 2'd3) xf = 2'd3;
    else xf = 2'd0;
    memv = w ? {bmem[ix + 5'd1], bmem[ix]} : {64'h0, bmem[ix]};
    cmpv = w ? {ehi, elo} : {64'h0, ehi[31:0], elo[31:0]};
    newv = w ? {nhi, nlo} : {64'h0, nhi[31:0], nlo[31:0]};
    xhi = ehi; xlo = elo; xeq = model_eq; after = memv;
    if (xf == 2'd0) begin
      xeq = (memv == cmpv);
      if (xeq) after = newv;
      else if (w) begin xhi = memv[127:64]; xlo = memv[63:0]; end
      else begin xhi = {32'h0, memv[63:32]}; xlo = {32'h0, memv[31:0]}; end
    end
    rd0 = n_rd; wr0 = n_wr;
    @(negedge clk);
    cur_wide = w;
    req_wide = w; req_addr = a; exp_hi = ehi; exp_lo = elo; new_hi = nhi; new_lo = nlo;
    align_chk_en = ac; cpl = pl; is_mem_opnd = ism; wide_feat_en = wen; req_valid = 1;
    @(posedge clk);
    #1 req_valid = 0;
    @(negedge clk);
    chk(req_ready == 0, {tag, " R10 busy"}, DW'(req_ready), 0);
    guard = 0;
    while (!done && guard < 100) begin @(negedge clk); guard++; end
    chk(done == 1, {tag, " R10 done seen"}, DW'(done), 1);
    chk(fault == xf, {tag, " fault code"}, DW'(fault), DW'(xf));
    chk(eq_flag == xeq, {tag, " eq flag"}, DW'(eq_flag), DW'(xeq));
    chk({res_hi, res_lo} == {xhi, xlo}, {tag, " result pair"}, {res_hi, res_lo}, {xhi, xlo});
    chk((n_rd - rd0) == (xf == 0 ? 1 : 0), {tag, " R3 read count"}, DW'(n_rd - rd0), DW'(xf == 0));
    chk((n_wr - wr0) == (xf == 0 ? 1 : 0), {tag, " R3 write count"}, DW'(n_wr - wr0), DW'(xf == 0));
    if (xf == 0) begin
      if (w) chk({bmem[ix + 5'd1], bmem[ix]} == after, {tag, " memory"}, {bmem[ix + 5'd1], bmem[ix]}, after);
      else   chk({64'h0, bmem[ix]} == after, {tag, " memory"}, {64'h0, bmem[ix]}, after);
      model_eq = xeq;
    end
    @(negedge clk);
    chk(done == 0, {tag, " R10 single pulse"}, DW'(done), 0);
    chk(req_ready == 1, {tag, " R10 idle again"}, DW'(req_ready), 1);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) bmem[k] = {32'hA000_0000 + 32'(k), 32'h5000_0000 + 32'(k)};
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(done == 0 && mem_req == 0 && mem_lock == 0, "reset bus idle", {mem_req, mem_lock, done}, 0);
    chk(eq_flag == 0 && fault == 0 && req_ready == 1, "reset flag", {eq_flag, fault, req_ready}, 4'h1);

    // R1: narrow match at doubleword 1
    run_op("R1 narrow match", 0, 32'h08, 64'hFFFF_FFFF_A000_0001, 64'h5000_0001,
           64'h1234_5678, 64'h9ABC_DEF0, 0, 0, 1, 1);
    // R2: narrow mismatch, old expectation against new contents
    run_op("R2 narrow miss", 0, 32'h08, 64'hA000_0001, 64'h5000_0001,
           64'h1, 64'h2, 0, 0, 1, 1);
    // R11: wide match and mismatch at doublewords 4/5
    run_op("R11 wide match", 1, 32'h20, 64'hA000_0005_5000_0005, 64'hA000_0004_5000_0004,
           64'hDEAD_BEEF_0000_1111, 64'hCAFE_F00D_2222_3333, 0, 0, 1, 1);
    run_op("R11 wide miss", 1, 32'h20, 64'hA000_0005_5000_0005, 64'hA000_0004_5000_0004,
           64'h7, 64'h8, 0, 0, 1, 1);
    // R11: low halves equal, high differs -> mismatch
    run_op("R11 wide high differs", 1, 32'h40, 64'hA000_0009_5000_0000, 64'hA000_0008_5000_0008,
           64'h3, 64'h4, 0, 0, 1, 1);
    // R5: wide misaligned, checking off and on
    run_op("R5 wide misalign ac off", 1, 32'h28, 64'h0, 64'h0, 64'h0, 64'h0, 0, 0, 1, 1);
    run_op("R5 wide misalign ac on", 1, 32'h24, 64'h11, 64'h22, 64'h0, 64'h0, 1, 3, 1, 1);
    // R6: feature disabled
    run_op("R6 wide feature off", 1, 32'h40, 64'hA000_0009_5000_0009, 64'hA000_0008_5000_0008,
           64'h5, 64'h6, 0, 0, 1, 0);
    // R7: non-memory wins over misalignment
    run_op("R7 not memory", 1, 32'h2C, 64'h33, 64'h44, 64'h0, 64'h0, 1, 3, 0, 0);
    // R8: narrow misaligned alignment fault only at level 3 with checking on
    run_op("R8 narrow ac fault", 0, 32'h0C, 64'h55, 64'h66, 64'h0, 64'h0, 1, 3, 1, 1);
    run_op("R8 narrow level0 runs", 0, 32'h0C, 64'hA000_0001, 64'h5000_0001, 64'h9, 64'hA, 1, 0, 1, 1);
    run_op("R8 narrow ac off runs", 0, 32'h14, 64'hA000_0002, 64'h5000_0002, 64'hB, 64'hC, 0, 3, 1, 1);
    // R9: fault after a match keeps flag set
    run_op("R9 fault keeps flag", 1, 32'h48, 64'h77, 64'h88, 64'h0, 64'h0, 0, 0, 1, 1);
    // back-to-back wide match
    run_op("R11 wide match 2", 1, 32'h60, 64'hA000_000D_5000_000D, 64'hA000_000C_5000_000C,
           64'h1111, 64'h2222, 0, 0, 1, 1);

    chk(lock_gaps == 0, "R4 lock continuity", DW'(lock_gaps), 0);
    finish_run();
  end

endmodule